// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the address of the next microinstruction for a microprogrammed control unit. It owns the control address register, which drives the address port of an external control store, and a one-entry return register used for a single level of microsubroutine nesting. Each cycle it looks at the branch-type field, the condition-select field and the target-address field of the microinstruction now being read, together with a few status bits of the surrounding datapath. It then loads the control address register from one of four places: the incremented address, the return register, the target field, or an entry point computed from the machine-instruction opcode.

The condition-select field picks a single test bit: a constant one, the indirect flag of the fetched instruction, the sign of the accumulator, or an all-zero accumulator. Jumps and calls are taken only when that bit is one. A call that is taken also saves the incremented address in the return register. A return, or an opcode dispatch, ignores the test bit. Opcode dispatch spaces the instruction routines four words apart from address zero. The fetch routine lives at address 64, where the sequencer starts after reset.

Top module: `micro_sequencer`

## Requirements
- R1: While `rstN` is low, `ctrlAddr` is 64 and the return register is 0. A return as the first step after reset therefore goes to address 0.
- R2: With `condSel` = 0 (always true) and `brType` = 0 (jump), the next `ctrlAddr` is `nextField`.
- R3: With `condSel` = 1, the test bit is `dirFlag`. A jump goes to `nextField` when it is 1 and to `ctrlAddr`+1 when it is 0.
- R4: With `condSel` = 2, the test bit is `accWord[DATA_W-1]`, the accumulator sign.
- R5: With `condSel` = 3, the test bit is 1 exactly when `accWord` is all zeros.
- R6: A jump or a call whose test bit is 0 loads `ctrlAddr`+1.
- R7: A call (`brType` = 1) whose test bit is 1 loads `nextField` and saves `ctrlAddr`+1 in the return register. A call whose test bit is 0 leaves the return register unchanged.
- R8: A return (`brType` = 2) loads the return register, whatever the test bit is.
- R9: A dispatch (`brType` = 3) loads the value `{0, opcode, 00}`, which is opcode times 4. The 16 routines therefore start at 0, 4, …, 60.
- R10: Incrementing wraps from 127 to 0.
- R11: The return register changes only on a taken call. Jumps, returns and dispatches keep it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the control address updates on every rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| condSel | input | 2 | Condition select of the current microinstruction |
| brType | input | 2 | Branch type: 0 jump, 1 call, 2 return, 3 dispatch |
| nextField | input | ADDR_W (7) | Target address field of the current microinstruction |
| dirFlag | input | 1 | Indirect flag of the fetched instruction |
| opcode | input | OPC_W (4) | Opcode bits of the fetched instruction |
| accWord | input | DATA_W (16) | Accumulator value, used for the sign and zero tests |
| ctrlAddr | output | ADDR_W (7) | Control address register, the address of the control store |

## Verification
Every condition source is driven with its test bit set and cleared while a jump is active. This separates the taken path from the fall-through path and shows that each `condSel` code reads the intended status input and no other. Taken and untaken calls are each followed, after intervening jumps and dispatches, by a return. The return target shows whether the return register was written, preserved or wrongly overwritten. All sixteen opcodes are dispatched to expose any slip in the bit placement of the mapped address. A jump to 127 followed by a fall-through exercises the wrap. A long pseudo-random mix of fields and status values is then compared against an independent reference model.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BR_JMP  = 2'd0,
    BR_CALL = 2'd1,
    BR_RET  = 2'd2,
    BR_MAP  = 2'd3
  } brKind_e;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'd0,
    CS_IND    = 2'd1,
    CS_SIGN   = 2'd2,
    CS_ZERO   = 2'd3
  } condKind_e;

  // source codes follow the {S1,S0} select of the address multiplexer
  typedef enum logic [1:0] {
    SRC_INC = 2'd0,
    SRC_SBR = 2'd1,
    SRC_AD  = 2'd2,
    SRC_MAP = 2'd3
  } srcSel_e;

  typedef struct packed {
    srcSel_e src;
    logic    sbrLoad;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        condSel,
  input  logic [1:0]        brType,
  input  logic              dirFlag,
  input  logic [DATA_W-1:0] accWord,
  output useq_pkg::seqStrobe_t strobe
);
  import useq_pkg::*;

  logic testBit;
  logic i0, i1, s0, s1;

  always_comb begin
    unique case (condKind_e'(condSel))
      CS_ALWAYS: testBit = 1'b1;
      CS_IND:    testBit = dirFlag;
      CS_SIGN:   testBit = accWord[DATA_W-1];
      default:   testBit = (accWord == '0);
    endcase
  end

  // i0 is the upper branch-type bit, i1 the lower one
  always_comb begin
    i0 = brType[1];
    i1 = brType[0];
    s0 = i0;
    s1 = (i0 & i1) | (~i0 & testBit);
    strobe.src     = srcSel_e'({s1, s0});
    strobe.sbrLoad = ~i0 & i1 & testBit;
  end

endmodule

// File: rtl/useq_path.sv
module useq_path #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  useq_pkg::seqStrobe_t strobe,
  input  logic [ADDR_W-1:0] nextField,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] carQ,
  output logic [ADDR_W-1:0] sbrQ
);
  import useq_pkg::*;

  localparam logic [ADDR_W-1:0] RST_CAR = ADDR_W'(RESET_ADDR);

  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] carD;

  assign incAddr = carQ + 1'b1;
  assign mapAddr = ADDR_W'(opcode) << MAP_SHIFT;

  always_comb begin
    unique case (strobe.src)
      SRC_INC: carD = incAddr;
      SRC_SBR: carD = sbrQ;
      SRC_AD:  carD = nextField;
      default: carD = mapAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carQ <= RST_CAR;
      sbrQ <= '0;
    end else begin
      carQ <= carD;
      if (strobe.sbrLoad) sbrQ <= incAddr;
    end
  end

endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int DATA_W     = 16,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        condSel,
  input  logic [1:0]        brType,
  input  logic [ADDR_W-1:0] nextField,
  input  logic              dirFlag,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] accWord,
  output logic [ADDR_W-1:0] ctrlAddr
);
  import useq_pkg::*;

  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] subrAddr;

  useq_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .condSel (condSel),
    .brType  (brType),
    .dirFlag (dirFlag),
    .accWord (accWord),
    .strobe  (strobe)
  );

  useq_path #(
    .ADDR_W     (ADDR_W),
    .OPC_W      (OPC_W),
    .MAP_SHIFT  (MAP_SHIFT),
    .RESET_ADDR (RESET_ADDR)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .nextField (nextField),
    .opcode    (opcode),
    .carQ      (ctrlAddr),
    .sbrQ      (subrAddr)
  );

endmodule

// File: rtl/micro_sequencer_chk.sv
module micro_sequencer_chk #(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int DATA_W     = 16,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        condSel,
  input logic [1:0]        brType,
  input logic [ADDR_W-1:0] nextField,
  input logic              dirFlag,
  input logic [OPC_W-1:0]  opcode,
  input logic [DATA_W-1:0] accWord,
  input logic [ADDR_W-1:0] ctrlAddr,
  input logic [ADDR_W-1:0] subrAddr
);

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ctrlAddr == ADDR_W'(RESET_ADDR))); // R1

  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd0 && condSel == 2'd0) |=> (ctrlAddr == $past(nextField))); // R2

  AST_IND_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd0 && condSel == 2'd1 && dirFlag) |=> (ctrlAddr == $past(nextField))); // R3

  AST_SIGN_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd0 && condSel == 2'd2 && accWord[DATA_W-1]) |=> (ctrlAddr == $past(nextField))); // R4

  AST_ZERO_FALLTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd0 && condSel == 2'd3 && accWord != '0)
      |=> (ctrlAddr == ADDR_W'($past(ctrlAddr) + 1'b1))); // R6

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd1 && condSel == 2'd0)
      |=> (subrAddr == ADDR_W'($past(ctrlAddr) + 1'b1))); // R7

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd2) |=> (ctrlAddr == $past(subrAddr))); // R8

  AST_MAP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 2'd3) |=> (ctrlAddr == (ADDR_W'($past(opcode)) << MAP_SHIFT))); // R9

  AST_SBR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (brType != 2'd1) |=> $stable(subrAddr)); // R11

endmodule

bind micro_sequencer micro_sequencer_chk #(
  .ADDR_W     (ADDR_W),
  .OPC_W      (OPC_W),
  .DATA_W     (DATA_W),
  .MAP_SHIFT  (MAP_SHIFT),
  .RESET_ADDR (RESET_ADDR)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .condSel   (condSel),
  .brType    (brType),
  .nextField (nextField),
  .dirFlag   (dirFlag),
  .opcode    (opcode),
  .accWord   (accWord),
  .ctrlAddr  (ctrlAddr),
  .subrAddr  (subrAddr)
);

// File: tb/micro_sequencer_test.sv
`timescale 1ns/1ps
module micro_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  condSel = '0;
  logic [1:0]  brType = '0;
  logic [6:0]  nextField = '0;
  logic        dirFlag = 1'b0;
  logic [3:0]  opcode = '0;
  logic [15:0] accWord = '0;
  logic [6:0]  ctrlAddr;

  int checks = 0;
  int fails  = 0;

  logic [6:0] modelCar = 7'd64;
  logic [6:0] modelSbr = 7'd0;

  logic [6:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  micro_sequencer uut (
    .clk       (clk),
    .rstN      (rstN),
    .condSel   (condSel),
    .brType    (brType),
    .nextField (nextField),
    .dirFlag   (dirFlag),
    .opcode    (opcode),
    .accWord   (accWord),
    .ctrlAddr  (ctrlAddr)
  );

  task automatic checkVal(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: ctrlAddr=%0d expected %0d", tag, got, exp);
    end
  endtask

  // driver: applies one microinstruction step and queues the expected address
  task automatic step(input logic [1:0] cd, input logic [1:0] br, input logic [6:0] ad,
                      input logic dir, input logic [3:0] op, input logic [15:0] ac,
                      input string tag);
    logic t;
    @(negedge clk);
    condSel = cd; brType = br; nextField = ad; dirFlag = dir; opcode = op; accWord = ac;
    case (cd)
      2'd0: t = 1'b1;
      2'd1: t = dir;
      2'd2: t = ac[15];
      default: t = (ac == 16'd0);
    endcase
    case (br)
      2'd0: modelCar = t ? ad : modelCar + 7'd1;
      2'd1: begin
        if (t) begin
          modelSbr = modelCar + 7'd1;
          modelCar = ad;
        end else modelCar = modelCar + 7'd1;
      end
      2'd2: modelCar = modelSbr;
      default: modelCar = {1'b0, op, 2'b00};
    endcase
    expQ.push_back(modelCar);
    tagQ.push_back(tag);
  endtask

  // monitor: compares just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [6:0] e;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        checkVal(tg, ctrlAddr, e);
      end
    end
  end

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R1 reset address", ctrlAddr, 7'd64);
    @(negedge clk);
    rstN = 1'b1;
    checkVal("R1 after release", ctrlAddr, 7'd64);

    step(2'd0, 2'd2, 7'd9,   1'b0, 4'd0, 16'h0000, "R1 return register cleared");
    step(2'd0, 2'd0, 7'd100, 1'b0, 4'd0, 16'h0000, "R2 unconditional jump");
    step(2'd1, 2'd0, 7'd5,   1'b0, 4'd0, 16'h0000, "R3 indirect clear falls through");
    step(2'd1, 2'd0, 7'd5,   1'b1, 4'd0, 16'h0000, "R3 indirect set jumps");
    step(2'd2, 2'd0, 7'd30,  1'b0, 4'd0, 16'h8000, "R4 sign set jumps");
    step(2'd2, 2'd0, 7'd90,  1'b1, 4'd0, 16'h7fff, "R4 sign clear falls through");
    step(2'd3, 2'd0, 7'd50,  1'b0, 4'd0, 16'h0000, "R5 zero accumulator jumps");
    step(2'd3, 2'd0, 7'd10,  1'b1, 4'd0, 16'h0100, "R6 nonzero accumulator falls through");
    step(2'd0, 2'd1, 7'd70,  1'b0, 4'd0, 16'h0000, "R7 taken call");
    step(2'd3, 2'd1, 7'd3,   1'b0, 4'd0, 16'h0001, "R7 untaken call");
    step(2'd0, 2'd3, 7'd0,   1'b0, 4'd6, 16'h0000, "R9 dispatch opcode 6");
    step(2'd2, 2'd0, 7'd2,   1'b0, 4'd0, 16'h0000, "R6 untaken jump");
    step(2'd0, 2'd2, 7'd0,   1'b0, 4'd0, 16'h0000, "R8 return after untaken call R11");
    step(2'd2, 2'd1, 7'd126, 1'b0, 4'd0, 16'h8000, "R7 conditional call taken");
    step(2'd0, 2'd0, 7'd127, 1'b0, 4'd0, 16'h0000, "R2 jump to top");
    step(2'd3, 2'd0, 7'd8,   1'b0, 4'd0, 16'h0005, "R10 wrap to zero");
    step(2'd0, 2'd3, 7'd0,   1'b0, 4'd9, 16'h0000, "R11 dispatch keeps return register");
    step(2'd3, 2'd2, 7'd0,   1'b0, 4'd0, 16'h0005, "R8 return with test bit clear");
    for (int k = 0; k < 16; k++)
      step(2'd0, 2'd3, 7'd1, 1'b0, 4'(k), 16'h0000, "R9 opcode dispatch sweep");
    for (int k = 0; k < 200; k++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[1:0], r[3:2], r[10:4], r[11], r[15:12],
           {r[16], (r[17] ? 15'd0 : r[31:17])}, "R2 R7 R8 R9 random mix");
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule